// File: doc/BRIEF.md
# Multi-Port TDM Frame Reference Selector

This block chooses the frame-sync reference for a local time-division-multiplexed bus from a set of line ports. Each port delivers an asynchronous frame-sync pulse once per nominal 125 us frame. The block resynchronises these pulses into the system clock domain and keeps a loss-of-sync flag for every port. It locks onto one live port that is configured for terminal-equipment operation and passes that port's frame pulses through as the bus reference.

When the locked port falls silent, the block moves to another live port. If no port is live, it can run an internal frame-pulse generator at the nominal frame rate. Software can override the automatic choice by forcing a given port, the internal generator, or no source at all. A change away from a source that is still delivering frames waits for that source's frame boundary, so a frame in progress is never cut short.

Top module: `tdm_ref_select`

## Requirements
- R1: After reset all loss flags read 1, `ref_src_o` holds the no-source code NPORTS+1 (5 with four ports), and `ref_sync_o` is 0.
- R2: A port's loss flag reads 0 from the cycle in which its resynchronised rising edge is passed on. It returns to 1 after TIMEOUT_FRAMES*FRAME_CLKS consecutive clocks without such an edge.
- R3: A port is live when its `te_mode_i` bit is 1 and its loss flag is 0. Automatic selection from the no-source or internal-generator state picks the live port with the lowest index. A port whose `te_mode_i` bit is 0 is never picked automatically, even when its loss flag is 0.
- R4: When the selected port stops being live, the next cycle selects the lowest-indexed live port. With no live port it selects the internal generator (code NPORTS) if `freerun_en_i` is 1, and otherwise the no-source code.
- R5: While the selected port stays live and no override is active, the selection does not change, even when a lower-indexed port becomes live.
- R6: The internal generator gives a one-clock pulse every FRAME_CLKS clocks. When it is selected, `ref_sync_o` repeats at that spacing. With the no-source code selected, `ref_sync_o` stays 0.
- R7: `ref_sync_o` is a one-clock pulse that follows the selected source. A port input that is high at rising clock edge k yields `ref_sync_o` high after edge k+2, so the spacing of the reference pulses equals the port's frame spacing.
- R8: With `force_en_i` at 1, `force_src_i` picks the source: 0..NPORTS-1 selects a port, NPORTS selects the internal generator, and any larger value selects no source. The live state, the `te_mode_i` bits and `freerun_en_i` do not affect a forced choice.
- R9: A switch away from a source that is still delivering frames (a live port, or the internal generator) happens only on that source's frame pulse. In the cycle where `ref_src_o` takes its new value, `ref_sync_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync_i | input | NPORTS | Asynchronous frame-sync input of each line port |
| te_mode_i | input | NPORTS | Per-port eligibility: 1 when the port runs as terminal equipment |
| freerun_en_i | input | 1 | Allows fallback to the internal frame generator |
| force_en_i | input | 1 | Enables the software override of the source |
| force_src_i | input | SW | Forced source code: port index, NPORTS for the internal generator, above that no source |
| ref_sync_o | output | 1 | Selected reference frame pulse, one clock wide |
| ref_src_o | output | SW | Code of the selected source |
| sync_lost_o | output | NPORTS | Per-port loss-of-sync flags |

## Verification
The assertions assume that a port's frame pulse stays high for at least one clock and recurs far less often than every other clock, so that two resynchronised edges of one port never land on adjacent cycles. They also assume that `te_mode_i` changes only during reset. The stimulus drives every port with two-clock pulses on a 20-clock frame and changes the eligibility mask only while reset is held. It changes the override and fallback controls only between frames, so every switch falls on a boundary that a reference model written in the bench can predict.

// File: rtl/tdm_ref_pkg.sv
package tdm_ref_pkg;

   // Index of the lowest set bit, or 32 when the vector is empty.
   function automatic int unsigned lowest_set(input logic [31:0] vec);
      for (int i = 0; i < 32; i++) begin
         if (vec[i]) return i;
      end
      return 32;
   endfunction

endpackage

// File: rtl/tdm_sync_edge.sv
module tdm_sync_edge #(
   parameter int NPORTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] raw_i,
   output logic [NPORTS-1:0] rise_o
);

   for (genvar g = 0; g < NPORTS; g++) begin : g_port
      // sh[0], sh[1] synchronise; sh[2] holds the previous synchronised value
      logic [2:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[1:0], raw_i[g]};
      end
      assign rise_o[g] = sh[1] & ~sh[2];
   end

endmodule

// File: rtl/tdm_loss_timer.sv
module tdm_loss_timer #(
   parameter int LIMIT = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   output logic lost_o
);

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         lost_o <= 1'b1;
      end else if (rise_i) begin
         cnt    <= '0;
         lost_o <= 1'b0;
      end else if (cnt == LAST) begin
         lost_o <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/tdm_freerun.sv
module tdm_freerun #(
   parameter int FRAME_CLKS = 31250
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse_o
);

   localparam int CW = (FRAME_CLKS > 2) ? $clog2(FRAME_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (cnt == LAST)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   assign pulse_o = (cnt == LAST);

endmodule

// File: rtl/tdm_src_arbiter.sv
module tdm_src_arbiter
   import tdm_ref_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int SW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] live_i,
   input  logic [NPORTS-1:0] rise_i,
   input  logic              fr_pulse_i,
   input  logic              freerun_en_i,
   input  logic              force_en_i,
   input  logic [SW-1:0]     force_src_i,
   output logic [SW-1:0]     src_o,
   output logic              ref_o
);

   localparam logic [SW-1:0] FR_C   = SW'(NPORTS);
   localparam logic [SW-1:0] NONE_C = SW'(NPORTS + 1);

   logic          cur_pulse, cur_live, cur_is_port, may_switch;
   logic [SW-1:0] want;
   int unsigned   lo;

   always_comb begin
      cur_pulse = 1'b0;
      cur_live  = 1'b0;
      for (int i = 0; i < NPORTS; i++) begin
         if (src_o == SW'(i)) begin
            cur_pulse = rise_i[i];
            cur_live  = live_i[i];
         end
      end
      if (src_o == FR_C) begin
         cur_pulse = fr_pulse_i;
         cur_live  = 1'b1;
      end
      cur_is_port = (src_o < FR_C);
      lo          = lowest_set(32'(live_i));

      if (force_en_i)                 want = (force_src_i > NONE_C) ? NONE_C : force_src_i;
      else if (cur_is_port && cur_live) want = src_o;
      else if (|live_i)               want = SW'(lo);
      else if (freerun_en_i)          want = FR_C;
      else                            want = NONE_C;

      // a running source is only left on its own frame pulse
      may_switch = cur_pulse | ~cur_live;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_o <= NONE_C;
         ref_o <= 1'b0;
      end else begin
         ref_o <= cur_pulse;
         if (may_switch) src_o <= want;
      end
   end

endmodule

// File: rtl/tdm_ref_select.sv
module tdm_ref_select #(
   parameter int NPORTS         = 4,
   parameter int FRAME_CLKS     = 31250,
   parameter int TIMEOUT_FRAMES = 4,
   parameter bit HAS_FREERUN    = 1'b1,
   parameter int SW             = $clog2(NPORTS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] line_sync_i,
   input  logic [NPORTS-1:0] te_mode_i,
   input  logic              freerun_en_i,
   input  logic              force_en_i,
   input  logic [SW-1:0]     force_src_i,
   output logic              ref_sync_o,
   output logic [SW-1:0]     ref_src_o,
   output logic [NPORTS-1:0] sync_lost_o
);

   localparam int LOSS_CLKS = FRAME_CLKS * TIMEOUT_FRAMES;

   initial begin
      param_ports_chk : assert (NPORTS >= 2 && NPORTS <= 32)
         else $fatal(1, "NPORTS out of range");
      param_frame_chk : assert (FRAME_CLKS >= 4 && TIMEOUT_FRAMES >= 1)
         else $fatal(1, "frame timing out of range");
      param_sw_chk : assert (SW >= $clog2(NPORTS + 2))
         else $fatal(1, "SW too narrow");
   end

   logic [NPORTS-1:0] rise_w;
   logic [NPORTS-1:0] active_w;
   logic              fr_pulse_w;

   tdm_sync_edge #(.NPORTS(NPORTS)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (line_sync_i),
      .rise_o (rise_w)
   );

   for (genvar g = 0; g < NPORTS; g++) begin : g_loss
      tdm_loss_timer #(.LIMIT(LOSS_CLKS)) u_loss (
         .clk    (clk),
         .rst_n  (rst_n),
         .rise_i (rise_w[g]),
         .lost_o (sync_lost_o[g])
      );
   end

   assign active_w = te_mode_i & ~sync_lost_o;

   if (HAS_FREERUN) begin : g_fr
      tdm_freerun #(.FRAME_CLKS(FRAME_CLKS)) u_fr (
         .clk     (clk),
         .rst_n   (rst_n),
         .pulse_o (fr_pulse_w)
      );
   end else begin : g_nofr
      assign fr_pulse_w = 1'b0;
   end

   tdm_src_arbiter #(.NPORTS(NPORTS), .SW(SW)) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .live_i       (active_w),
      .rise_i       (rise_w),
      .fr_pulse_i   (fr_pulse_w),
      .freerun_en_i (freerun_en_i),
      .force_en_i   (force_en_i),
      .force_src_i  (force_src_i),
      .src_o        (ref_src_o),
      .ref_o        (ref_sync_o)
   );

endmodule

// File: rtl/tdm_ref_select_chk.sv
module tdm_ref_select_chk #(
   parameter int NPORTS = 4,
   parameter int SW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPORTS-1:0] rise_w,
   input logic [NPORTS-1:0] active_w,
   input logic [NPORTS-1:0] sync_lost_o,
   input logic              ref_sync_o,
   input logic [SW-1:0]     ref_src_o,
   input logic              force_en_i,
   input logic              freerun_en_i
);

   localparam logic [SW-1:0] FR_C   = SW'(NPORTS);
   localparam logic [SW-1:0] NONE_C = SW'(NPORTS + 1);

   logic sel_running;
   always_comb begin
      sel_running = (ref_src_o == FR_C);
      for (int i = 0; i < NPORTS; i++)
         if (ref_src_o == SW'(i)) sel_running = active_w[i];
   end

   for (genvar g = 0; g < NPORTS; g++) begin : g_p
      // R2
      lost_clear_chk : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sync_lost_o[g]) |-> $past(rise_w[g]));
      // R2
      edge_clears_chk : assert property (@(posedge clk) disable iff (!rst_n)
         rise_w[g] |=> !sync_lost_o[g]);
   end

   // R9
   boundary_switch_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_running) && (ref_src_o != $past(ref_src_o))) |-> ref_sync_o);

   // R4
   fallback_enable_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ((ref_src_o == FR_C) && (ref_src_o != $past(ref_src_o)) && !$past(force_en_i))
         |-> $past(freerun_en_i));

   // R6
   no_source_quiet_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ref_sync_o |-> ($past(ref_src_o) != NONE_C));

   // R4
   code_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ref_src_o <= NONE_C);

endmodule

bind tdm_ref_select tdm_ref_select_chk #(.NPORTS(NPORTS), .SW(SW)) chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rise_w       (rise_w),
   .active_w     (active_w),
   .sync_lost_o  (sync_lost_o),
   .ref_sync_o   (ref_sync_o),
   .ref_src_o    (ref_src_o),
   .force_en_i   (force_en_i),
   .freerun_en_i (freerun_en_i)
);

// File: tb/tdm_ref_select_test.sv
module tdm_ref_select_test;

   localparam int N = 4, F = 20, TF = 4, L = F * TF, SW = 3;
   localparam int FR = N, NONE = N + 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  line_sync, te_mode;
   logic          fr_en, force_en;
   logic [SW-1:0] force_src;
   logic          ref_sync_o;
   logic [SW-1:0] ref_src_o;
   logic [N-1:0]  sync_lost_o;

   tdm_ref_select #(.NPORTS(N), .FRAME_CLKS(F), .TIMEOUT_FRAMES(TF)) uut (
      .clk(clk), .rst_n(rst_n), .line_sync_i(line_sync), .te_mode_i(te_mode),
      .freerun_en_i(fr_en), .force_en_i(force_en), .force_src_i(force_src),
      .ref_sync_o(ref_sync_o), .ref_src_o(ref_src_o), .sync_lost_o(sync_lost_o));

   always #2 clk = ~clk;

   int checks = 0, errors = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // stimulus controls
   bit            c_rst = 1'b1;
   bit [N-1:0]    c_te = '0;
   bit            c_fr = 1'b0, c_force = 1'b0;
   int            c_fsrc = 0;
   bit            run [N];
   int            off [N];
   int            ctr [N];

   // reference model state
   bit m_s1 [N], m_s2 [N], m_s3 [N], m_lost [N];
   int m_cnt [N];
   int m_fr = 0, m_cur = NONE;
   bit m_ref = 1'b0;

   int  cyc = 0, last_ref = -1, last_gap = -1, ref_cnt = 0, prev_src = NONE;
   bit  done = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n === 1'b1) begin
         for (int i = 0; i < N; i++)
            check(sync_lost_o[i] === m_lost[i], "R2", int'(sync_lost_o[i]), int'(m_lost[i]));
         check(ref_src_o === SW'(m_cur), "R4", int'(ref_src_o), m_cur);
         check(ref_sync_o === m_ref, "R7", int'(ref_sync_o), int'(m_ref));
         // R9: leaving a running forced-away port must coincide with its pulse
         if (c_force && prev_src < N && int'(ref_src_o) != prev_src && run[prev_src] && c_te[prev_src])
            check(ref_sync_o === 1'b1, "R9", int'(ref_sync_o), 1);
         if (ref_sync_o === 1'b1) begin
            if (last_ref >= 0) last_gap = cyc - last_ref;
            last_ref = cyc;
            ref_cnt++;
         end
         prev_src = int'(ref_src_o);
      end
      if (cyc > 100000 && !done) begin
         check(1'b0, "watchdog", cyc, 100000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
      // drive inputs for the next rising edge
      rst_n     = ~c_rst;
      te_mode   = c_te;
      fr_en     = c_fr;
      force_en  = c_force;
      force_src = SW'(c_fsrc);
      for (int i = 0; i < N; i++) begin
         if (run[i]) begin
            line_sync[i] = ((ctr[i] % F) < 2);
            ctr[i]++;
         end else begin
            line_sync[i] = 1'b0;
            ctr[i] = off[i];
         end
      end
      // step the model across that edge
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_lost[i] = 1; m_cnt[i] = 0;
         end
         m_fr = 0; m_cur = NONE; m_ref = 0;
      end else begin
         bit rise [N];
         bit live [N];
         bit frp, cpulse, clive, any;
         int lo, want;
         frp = (m_fr == F - 1);
         any = 0; lo = -1;
         for (int i = 0; i < N; i++) begin
            rise[i] = m_s2[i] && !m_s3[i];
            live[i] = !m_lost[i] && te_mode[i];
            if (live[i] && !any) begin any = 1; lo = i; end
         end
         if (m_cur < N)       begin cpulse = rise[m_cur]; clive = live[m_cur]; end
         else if (m_cur == FR) begin cpulse = frp; clive = 1; end
         else                 begin cpulse = 0; clive = 0; end
         if (force_en)                  want = (int'(force_src) > NONE) ? NONE : int'(force_src);
         else if (m_cur < N && clive)   want = m_cur;
         else if (any)                  want = lo;
         else if (fr_en)                want = FR;
         else                           want = NONE;
         m_ref = cpulse;
         if (cpulse || !clive) m_cur = want;
         for (int i = 0; i < N; i++) begin
            if (rise[i]) begin m_cnt[i] = 0; m_lost[i] = 0; end
            else if (m_cnt[i] == L - 1) m_lost[i] = 1;
            else m_cnt[i]++;
            m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = line_sync[i];
         end
         m_fr = frp ? 0 : m_fr + 1;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      int snap;
      for (int i = 0; i < N; i++) begin run[i] = 0; off[i] = 0; ctr[i] = 0; end
      off[0] = 3; off[1] = 5; off[2] = 0; off[3] = 10;
      c_te = 4'b1101;               // port 1 is not eligible
      wait_cyc(6);
      c_rst = 1'b0;
      wait_cyc(2);
      // R1
      check(sync_lost_o === 4'hF, "R1", int'(sync_lost_o), 15);
      check(ref_src_o === SW'(NONE), "R1", int'(ref_src_o), NONE);
      check(ref_sync_o === 1'b0, "R1", int'(ref_sync_o), 0);

      run[2] = 1; run[3] = 1; run[1] = 1;
      wait_cyc(100);
      // R3
      check(ref_src_o === 3'd2, "R3", int'(ref_src_o), 2);
      check(sync_lost_o === 4'b0001, "R2", int'(sync_lost_o), 1);
      check(last_gap == F, "R7", last_gap, F);

      run[0] = 1;
      wait_cyc(100);
      // R5
      check(ref_src_o === 3'd2, "R5", int'(ref_src_o), 2);
      check(sync_lost_o[0] === 1'b0, "R2", int'(sync_lost_o[0]), 0);

      run[2] = 0;
      wait_cyc(120);
      // R4
      check(ref_src_o === 3'd0, "R4", int'(ref_src_o), 0);
      check(sync_lost_o[2] === 1'b1, "R2", int'(sync_lost_o[2]), 1);

      c_force = 1'b1; c_fsrc = 3;
      wait_cyc(40);
      // R8
      check(ref_src_o === 3'd3, "R8", int'(ref_src_o), 3);
      c_fsrc = FR;
      wait_cyc(40);
      check(ref_src_o === SW'(FR), "R8", int'(ref_src_o), FR);
      check(last_gap == F, "R6", last_gap, F);

      c_force = 1'b0;
      wait_cyc(40);
      // R3: from the generator back to the lowest live port
      check(ref_src_o === 3'd0, "R3", int'(ref_src_o), 0);

      for (int i = 0; i < N; i++) run[i] = 0;
      c_fr = 1'b1;
      wait_cyc(150);
      // R6
      check(ref_src_o === SW'(FR), "R6", int'(ref_src_o), FR);
      check(sync_lost_o === 4'hF, "R2", int'(sync_lost_o), 15);
      check(last_gap == F, "R6", last_gap, F);

      c_fr = 1'b0;
      wait_cyc(40);
      check(ref_src_o === SW'(NONE), "R4", int'(ref_src_o), NONE);
      snap = ref_cnt;
      wait_cyc(60);
      check(ref_cnt == snap, "R6", ref_cnt - snap, 0);

      c_force = 1'b1; c_fsrc = 7;
      wait_cyc(10);
      // R8: out-of-range code means no source
      check(ref_src_o === SW'(NONE), "R8", int'(ref_src_o), NONE);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule